// File: doc/BRIEF.md
# Configurable Serial Shift Unit

This block is a small serial engine for a microcontroller. It holds an 8-bit shift register and a 4-bit edge counter. Software reaches it through a write port and a combinational read port. A wire-mode field decides how the shift register output reaches the pads. In three-wire mode a dedicated data-out pin is overridden. In the two open-drain two-wire modes the data and clock lines are pulled low. The block can also be switched off entirely.

A clock-source field and a strobe-select bit decide what advances the shift register and the counter. The choices are a software strobe written through the control register, a timer compare pulse, or edges of the external serial clock. With the external clock, the counter can instead be advanced by a separate software toggle strobe. In the two-wire modes a bus start condition stretches the clock line low until software clears the start flag. In the holding variant a counter wrap does the same until the wrap flag is cleared.

Register map (byte-wide). Address 0 is the shift register. Address 1 is status: bit 7 is the start flag, bit 6 is the wrap flag, bits 3:0 are the counter. Address 2 is control: bits 5:4 are the wire mode, bits 3:2 are the clock source, bit 1 is the strobe select, and bit 0 is a write-only toggle strobe that reads as 0. Unused bits read 0 and address 3 reads 0.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset, every register reads 0 and `do_ovr`, `do_val`, `sda_low`, `scl_low` are all 0.
- R2: With wire mode 00, `do_ovr`, `do_val`, `sda_low` and `scl_low` stay 0 and no start condition is detected.
- R3: With wire mode 01, `do_ovr` is 1 and `do_val` carries the output bit. `sda_low` and `scl_low` stay 0.
- R4: With wire mode 10 or 11, `sda_low` is 1 exactly when the output bit or `port_sda` is 0. `scl_low` is 1 when `port_scl` is 0 or a hold is active. `do_ovr` is 0.
- R5: In any nonzero wire mode, a falling `sda_in` while `scl_in` is high sets the start flag (status bit 7). Both pads pass through two synchronizing flops first. In modes 10 and 11 the flag holds `scl_low` at 1 until a status write with bit 7 set clears it.
- R6: In mode 11, a set wrap flag holds `scl_low` at 1 until a status write with bit 6 set clears it. In mode 10 the wrap flag does not affect `scl_low`.
- R7: With clock source 00, a control write carrying source 00 and bit 1 set shifts once and counts once. A write with bit 1 clear does neither. The shift moves the MSB out first and takes the synchronized `sda_in` in at the LSB.
- R8: With clock source 01, each cycle of `tmr_match` high shifts once and counts once.
- R9: Clock source 10 shifts on the rising external clock edge and source 11 shifts on the falling edge. With strobe select 0, the counter advances on both edges.
- R10: With an external source and strobe select 1, external edges still shift but do not count. A control write with bits 3, 1 and 0 set advances the counter once.
- R11: With source 00 or 01 the output bit follows the shift register MSB immediately. With source 10 the output bit is latched on the falling edge, and with source 11 on the rising edge.
- R12: The counter wraps from 15 to 0 and sets the sticky wrap flag. A status write loads the counter from bits 3:0 and clears each flag whose bit is written 1. A flag written 0 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data (combinational) |
| tmr_match | input | 1 | Timer compare pulse |
| sda_in | input | 1 | Data pad input (data-in / SDA) |
| scl_in | input | 1 | Clock pad input |
| port_sda | input | 1 | Port register bit for the data pad |
| port_scl | input | 1 | Port register bit for the clock pad |
| do_ovr | output | 1 | Data-out pin override active |
| do_val | output | 1 | Data-out pin value |
| sda_low | output | 1 | Pull data line low |
| scl_low | output | 1 | Pull clock line low |

## Verification
The properties assume that software never writes the status register in the same cycle it expects a wrap to be flagged. The stimulus keeps the two events in separate cycles. The properties also assume that pad inputs change far less often than once per clock. The bench holds every pad level for several cycles, so each edge passes the synchronizer as a single event. The stimulus moves `sda_in` only while `scl_in` is low, except where a start condition is wanted on purpose, so no start flag is raised by accident.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

    localparam int DATA_W   = 8;
    localparam int CNT_W    = 4;

    localparam int STAT_START_BIT = 7;
    localparam int STAT_WRAP_BIT  = 6;
    localparam int CTRL_TOGGLE_BIT = 0;

    typedef enum logic [1:0] {
        WM_OFF       = 2'b00,
        WM_THREE     = 2'b01,
        WM_TWO       = 2'b10,
        WM_TWO_HOLD  = 2'b11
    } wire_mode_e;

    typedef enum logic [1:0] {
        CS_SOFT      = 2'b00,
        CS_TIMER     = 2'b01,
        CS_EXT_RISE  = 2'b10,
        CS_EXT_FALL  = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        RA_DATA = 2'b00,
        RA_STAT = 2'b01,
        RA_CTRL = 2'b10,
        RA_NONE = 2'b11
    } reg_addr_e;

    typedef struct packed {
        wire_mode_e mode;
        clk_src_e   src;
        logic       strobe_sel;
    } ctrl_t;

    typedef struct packed {
        logic shift;
        logic count;
        logic latch;
        logic transparent;
    } tick_t;

    function automatic ctrl_t decode_ctrl(input logic [5:1] bits);
        ctrl_t c;
        c.mode       = wire_mode_e'(bits[5:4]);
        c.src        = clk_src_e'(bits[3:2]);
        c.strobe_sel = bits[1];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] encode_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] v;
        v      = '0;
        v[5:4] = c.mode;
        v[3:2] = c.src;
        v[1]   = c.strobe_sel;
        return v;
    endfunction

endpackage

// File: rtl/ssu_sync.sv
module ssu_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic sync,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= chain[STAGES-1];
    end

    assign sync = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/ssu_clkgen.sv
module ssu_clkgen
    import ssu_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  soft_strobe,
    input  logic  toggle_strobe,
    input  logic  tmr_match,
    input  logic  ext_rise,
    input  logic  ext_fall,
    output tick_t ticks
);
    logic ext_shift;
    logic ext_count;
    logic ext_latch;

    always_comb begin
        ext_shift = 1'b0;
        ext_latch = 1'b0;
        unique case (ctrl.src)
            CS_EXT_RISE: begin
                ext_shift = ext_rise;
                ext_latch = ext_fall;
            end
            CS_EXT_FALL: begin
                ext_shift = ext_fall;
                ext_latch = ext_rise;
            end
            default: begin
                ext_shift = 1'b0;
                ext_latch = 1'b0;
            end
        endcase
        ext_count = ctrl.src[1] & ~ctrl.strobe_sel & (ext_rise | ext_fall);
    end

    always_comb begin
        ticks.shift       = soft_strobe
                          | ((ctrl.src == CS_TIMER) & tmr_match)
                          | ext_shift;
        ticks.count       = soft_strobe
                          | ((ctrl.src == CS_TIMER) & tmr_match)
                          | ext_count
                          | toggle_strobe;
        ticks.latch       = ext_latch;
        ticks.transparent = ~ctrl.src[1];
    end
endmodule

// File: rtl/ssu_shifter.sv
module ssu_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    input  logic         din,
    input  logic         latch_en,
    input  logic         transparent,
    output logic [W-1:0] q,
    output logic         out_bit
);
    logic latch_q;

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= load_data;
        else if (shift) q <= {q[W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst)           latch_q <= 1'b0;
        else if (latch_en) latch_q <= q[W-1];
    end

    assign out_bit = transparent ? q[W-1] : latch_q;
endmodule

// File: rtl/ssu_counter.sv
module ssu_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (tick) count <= count + 1'b1;
    end

    assign wrap = tick & ~load & (count == TOP);
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
    import ssu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tmr_match,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              port_sda,
    input  logic              port_scl,
    output logic              do_ovr,
    output logic              do_val,
    output logic              sda_low,
    output logic              scl_low
);
    localparam int STAT_PAD = DATA_W - 2 - CNT_W;

    // Register write decode
    logic  data_wr, stat_wr, ctrl_wr;
    ctrl_t ctrl_q, ctrl_new;
    logic  soft_strobe, toggle_strobe;

    assign data_wr  = wr_en && (reg_addr_e'(wr_addr) == RA_DATA);
    assign stat_wr  = wr_en && (reg_addr_e'(wr_addr) == RA_STAT);
    assign ctrl_wr  = wr_en && (reg_addr_e'(wr_addr) == RA_CTRL);
    assign ctrl_new = decode_ctrl(wr_data[5:1]);

    assign soft_strobe   = ctrl_wr && (ctrl_new.src == CS_SOFT) && ctrl_new.strobe_sel;
    assign toggle_strobe = ctrl_wr && ctrl_new.src[1] && ctrl_new.strobe_sel
                           && wr_data[CTRL_TOGGLE_BIT];

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '{mode: WM_OFF, src: CS_SOFT, strobe_sel: 1'b0};
        else if (ctrl_wr) ctrl_q <= ctrl_new;
    end

    // Pad synchronizers
    logic sda_s, sda_rise, sda_fall;
    logic scl_s, scl_rise, scl_fall;

    ssu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst(rst), .din(sda_in),
        .sync(sda_s), .rise(sda_rise), .fall(sda_fall)
    );

    ssu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst(rst), .din(scl_in),
        .sync(scl_s), .rise(scl_rise), .fall(scl_fall)
    );

    // Clock selection
    tick_t ticks;

    ssu_clkgen u_clkgen (
        .ctrl(ctrl_q),
        .soft_strobe(soft_strobe),
        .toggle_strobe(toggle_strobe),
        .tmr_match(tmr_match),
        .ext_rise(scl_rise),
        .ext_fall(scl_fall),
        .ticks(ticks)
    );

    // Datapath
    logic [DATA_W-1:0] sr_q;
    logic              out_bit;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_wrap;

    ssu_shifter #(.W(DATA_W)) u_shifter (
        .clk(clk), .rst(rst),
        .load(data_wr), .load_data(wr_data),
        .shift(ticks.shift), .din(sda_s),
        .latch_en(ticks.latch), .transparent(ticks.transparent),
        .q(sr_q), .out_bit(out_bit)
    );

    ssu_counter #(.W(CNT_W)) u_counter (
        .clk(clk), .rst(rst),
        .load(stat_wr), .load_val(wr_data[CNT_W-1:0]),
        .tick(ticks.count),
        .count(cnt_q), .wrap(cnt_wrap)
    );

    // Flags
    logic start_flag, wrap_flag;
    logic start_evt, clr_start, clr_wrap;

    assign start_evt = (ctrl_q.mode != WM_OFF) && sda_fall && scl_s;
    assign clr_start = stat_wr && wr_data[STAT_START_BIT];
    assign clr_wrap  = stat_wr && wr_data[STAT_WRAP_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            start_flag <= 1'b0;
            wrap_flag  <= 1'b0;
        end else begin
            start_flag <= (start_flag & ~clr_start) | start_evt;
            wrap_flag  <= (wrap_flag & ~clr_wrap) | cnt_wrap;
        end
    end

    // Pad drive
    logic two_wire, hold_start, hold_wrap;

    assign two_wire   = ctrl_q.mode[1];
    assign hold_start = two_wire & start_flag;
    assign hold_wrap  = (ctrl_q.mode == WM_TWO_HOLD) & wrap_flag;

    assign do_ovr  = (ctrl_q.mode == WM_THREE);
    assign do_val  = do_ovr & out_bit;
    assign sda_low = two_wire & ~(out_bit & port_sda);
    assign scl_low = two_wire & (~port_scl | hold_start | hold_wrap);

    // Read mux
    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            RA_DATA: rd_data = sr_q;
            RA_STAT: rd_data = {start_flag, wrap_flag, {STAT_PAD{1'b0}}, cnt_q};
            RA_CTRL: rd_data = encode_ctrl(ctrl_q);
            default: rd_data = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{wr_data[7:6], wr_data[5:4] & 2'b00, sda_rise};

    logic [1:0] mode_bits, src_bits;
    assign mode_bits = ctrl_q.mode;
    assign src_bits  = ctrl_q.src;
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode,
    input logic [1:0]    src,
    input logic          port_scl,
    input logic          start_flag,
    input logic          wrap_flag,
    input logic          clr_wrap,
    input logic          sda_low,
    input logic          scl_low,
    input logic          do_ovr,
    input logic          do_val,
    input logic          sr_msb,
    input logic [CW-1:0] cnt,
    input logic          cnt_tick,
    input logic          cnt_load
);
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |-> (!sda_low && !scl_low && !do_ovr && !do_val));

    assert_start_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && start_flag) |-> scl_low);

    assert_no_wrap_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && port_scl && !start_flag) |-> !scl_low);

    assert_wrap_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && wrap_flag) |-> scl_low);

    assert_transparent_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !src[1]) |-> (do_val == sr_msb));

    assert_count_step_R12: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && !cnt_load) |=> (cnt == $past(cnt) + 1'b1));

    assert_wrap_sets_R12: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && !cnt_load && (&cnt)) |=> wrap_flag);

    assert_wrap_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (wrap_flag && !clr_wrap) |=> wrap_flag);
endmodule

bind serial_shift_unit ssu_checker #(.CW(ssu_pkg::CNT_W)) u_ssu_checker (
    .clk(clk),
    .rst(rst),
    .mode(mode_bits),
    .src(src_bits),
    .port_scl(port_scl),
    .start_flag(start_flag),
    .wrap_flag(wrap_flag),
    .clr_wrap(clr_wrap),
    .sda_low(sda_low),
    .scl_low(scl_low),
    .do_ovr(do_ovr),
    .do_val(do_val),
    .sr_msb(sr_q[ssu_pkg::DATA_W-1]),
    .cnt(cnt_q),
    .cnt_tick(ticks.count),
    .cnt_load(stat_wr)
);

// File: tb/serial_shift_unit_bench.sv
module serial_shift_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    // {ctrl, data, port_sda, port_scl, do_ovr, do_val, sda_low, scl_low}
    localparam logic [21:0] VECS [NVEC] = '{
        {8'h00, 8'h80, 1'b1, 1'b1, 4'b0000},
        {8'h00, 8'h00, 1'b0, 1'b0, 4'b0000},
        {8'h10, 8'h80, 1'b1, 1'b1, 4'b1100},
        {8'h10, 8'h7F, 1'b0, 1'b0, 4'b1000},
        {8'h20, 8'h80, 1'b1, 1'b1, 4'b0000},
        {8'h20, 8'h00, 1'b1, 1'b1, 4'b0010},
        {8'h20, 8'h80, 1'b0, 1'b1, 4'b0010},
        {8'h20, 8'h80, 1'b1, 1'b0, 4'b0001},
        {8'h30, 8'h00, 1'b1, 1'b0, 4'b0011}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_addr = 2'b00;
    logic [7:0] rd_data;
    logic       tmr_match = 1'b0;
    logic       sda_in = 1'b1;
    logic       scl_in = 1'b1;
    logic       port_sda = 1'b1;
    logic       port_scl = 1'b1;
    logic       do_ovr, do_val, sda_low, scl_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    serial_shift_unit u_serial_shift_unit (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_match(tmr_match),
        .sda_in(sda_in), .scl_in(scl_in),
        .port_sda(port_sda), .port_scl(port_scl),
        .do_ovr(do_ovr), .do_val(do_val),
        .sda_low(sda_low), .scl_low(scl_low)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic outs_chk(input string tag, input logic [3:0] exp);
        chk(tag, {4'b0, do_ovr, do_val, sda_low, scl_low}, {4'b0, exp});
    endtask

    task automatic pads(input logic sda, input logic scl);
        sda_in = sda; scl_in = scl;
        repeat (4) @(negedge clk);
    endtask

    task automatic tmr_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tmr_match = 1'b1;
            @(negedge clk) tmr_match = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 data", 2'd0, 8'h00);
        rd_chk("R1 status", 2'd1, 8'h00);
        rd_chk("R1 ctrl", 2'd2, 8'h00);
        outs_chk("R1 outputs", 4'b0000);

        // R2 R3 R4 pad drive table
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd2, VECS[i][21:14]);
            wr(2'd0, VECS[i][13:6]);
            port_sda = VECS[i][5];
            port_scl = VECS[i][4];
            #1;
            outs_chk($sformatf("R2/R3/R4 vector %0d", i), VECS[i][3:0]);
        end
        port_sda = 1'b1; port_scl = 1'b1;
        rd_chk("R7 table writes do not count", 2'd1, 8'h00);

        // R7 software strobe, MSB first, input at LSB
        wr(2'd2, 8'h10);
        pads(1'b0, 1'b0);
        wr(2'd1, 8'hC0);
        wr(2'd0, 8'hA5);
        wr(2'd2, 8'h12);
        rd_chk("R7 strobe shift", 2'd0, 8'h4A);
        outs_chk("R11 soft immediate 0", 4'b1000);
        wr(2'd2, 8'h12);
        rd_chk("R7 second shift", 2'd0, 8'h94);
        outs_chk("R11 soft immediate 1", 4'b1100);
        wr(2'd2, 8'h10);
        rd_chk("R7 no strobe", 2'd0, 8'h94);
        rd_chk("R7 count", 2'd1, 8'h02);

        // R8 timer pulses
        pads(1'b1, 1'b0);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h14);
        tmr_pulses(3);
        rd_chk("R8 timer shift", 2'd0, 8'h0F);
        rd_chk("R8 timer count", 2'd1, 8'h03);

        // R9 R11 external rising source
        wr(2'd2, 8'h18);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hC0);
        outs_chk("R11 ext latch not yet updated", 4'b1000);
        pads(1'b1, 1'b1);
        rd_chk("R9 rise shift", 2'd0, 8'h81);
        outs_chk("R11 rise keeps latch", 4'b1000);
        pads(1'b1, 1'b0);
        outs_chk("R11 fall updates latch", 4'b1100);
        rd_chk("R9 both edges counted", 2'd1, 8'h02);

        // R9 R11 external falling source
        wr(2'd2, 8'h1C);
        pads(1'b0, 1'b0);
        pads(1'b0, 1'b1);
        pads(1'b0, 1'b0);
        rd_chk("R9 fall shift", 2'd0, 8'h02);
        outs_chk("R11 fall keeps latch", 4'b1100);
        pads(1'b0, 1'b1);
        outs_chk("R11 rise updates latch", 4'b1000);
        rd_chk("R9 count both edges", 2'd1, 8'h05);

        // R10 toggle strobe counting
        wr(2'd2, 8'h1E);
        pads(1'b0, 1'b0);
        pads(1'b0, 1'b1);
        rd_chk("R10 edges do not count", 2'd1, 8'h05);
        rd_chk("R10 edges still shift", 2'd0, 8'h04);
        wr(2'd2, 8'h1F);
        rd_chk("R10 toggle counts", 2'd1, 8'h06);
        rd_chk("R10 toggle bit reads 0", 2'd2, 8'h1E);

        // R6 R12 wrap in mode 11
        wr(2'd2, 8'h30);
        pads(1'b1, 1'b1);
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'h32);
        rd_chk("R12 wrap sets flag", 2'd1, 8'h40);
        chk("R6 hold after wrap", {7'b0, scl_low}, 8'h01);
        wr(2'd1, 8'h05);
        rd_chk("R12 flag written 0 stays", 2'd1, 8'h45);
        wr(2'd1, 8'h40);
        rd_chk("R12 flag cleared", 2'd1, 8'h00);
        chk("R6 release", {7'b0, scl_low}, 8'h00);

        // R6 mode 10 ignores wrap
        wr(2'd2, 8'h20);
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'h22);
        rd_chk("R6 mode10 wrap flag", 2'd1, 8'h40);
        chk("R6 mode10 no hold", {7'b0, scl_low}, 8'h00);
        wr(2'd1, 8'hC0);

        // R5 start condition
        wr(2'd2, 8'h20);
        pads(1'b0, 1'b1);
        rd_chk("R5 start flag", 2'd1, 8'h80);
        chk("R5 start hold", {7'b0, scl_low}, 8'h01);
        wr(2'd1, 8'h80);
        rd_chk("R5 flag cleared", 2'd1, 8'h00);
        chk("R5 release", {7'b0, scl_low}, 8'h00);
        pads(1'b1, 1'b1);

        // R2 no start detection when off
        wr(2'd2, 8'h00);
        pads(1'b0, 1'b1);
        rd_chk("R2 no start when off", 2'd1, 8'h00);
        outs_chk("R2 off outputs", 4'b0000);
        pads(1'b1, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule